// File: doc/BRIEF.md
# Byte-Lane Bus Cycle Master

This block turns one transfer request from an internal core into bus cycles on a 32-bit data bus with separate address lines. The request carries a byte address, a size (8, 16 or 32 bits), a direction, an I/O-versus-memory select and a code-versus-data select. The two lowest address bits never reach the bus. They are folded together with the size into four active-low byte-lane enables, and the bus sees only the word address. Each cycle is labelled with a 3-bit cycle-definition code and is opened by a one-clock active-low address strobe.

The block holds the cycle with wait states until the external active-low ready input is sampled low. It then completes the write, or returns the read data right-aligned to the core. A transfer whose bytes run past lane 3 becomes two bus cycles: the first covers the starting lane through lane 3, and the second goes to the next word address starting at lane 0. Read data from both cycles is merged before a single completion pulse. The address width is a parameter, with 32 for the wide mode and 20 for the narrow mode.

Top module: `bcm_bus_master`

## Requirements
- R1: `bus_waddr` equals request address bits ADDR_W-1 down to 2 during the first bus cycle, and that value plus one during the second cycle of a split transfer. Address bits 1:0 are not output.
- R2: `bus_be_n` bit k is low when lane k (data bits 8k+7:8k) carries a byte of the transfer. Size code 0 is one byte at lane = addr[1:0]. Code 1 is two bytes from that lane. Codes 2 and 3 are four bytes from that lane.
- R3: When the byte span reaches past lane 3, two bus cycles are run. The second cycle's enables cover the overflowing bytes, starting at lane 0.
- R4: The code `{bus_mio, bus_dc, bus_wr}` is 010 for an I/O read and 011 for an I/O write. For memory it is 100 for a read with `req_code`=1, 110 for a read with `req_code`=0, and 111 for a write. `req_code` has no effect on I/O cycles or on writes. Codes 000, 001 and 101 are never presented with the strobe.
- R5: `bus_ads_n` is low for exactly one clock, in the cycle after a request is accepted (and after the first cycle's ready for a split). Address, enables and code stay unchanged until ready is sampled.
- R6: After the strobe clock, every clock edge with `bus_rdy_n` high adds one wait state. The cycle ends only on an edge where `bus_rdy_n` is low.
- R7: For writes, `bus_wdata_oe` is high from the clock after the strobe until ready. Each enabled lane carries the request byte whose index equals its position in the span. For reads, `bus_wdata_oe` stays low.
- R8: `rsp_done` pulses for one clock, one cycle after the ready edge of the last bus cycle. For reads, `rsp_rdata` then holds the transfer's bytes right-aligned, with bytes beyond the size set to zero.
- R9: While idle, `req_ready` is high, `bus_ads_n` is high and `bus_be_n` is 4'hF. A request is accepted only while idle; `req_valid` during a transfer has no effect on that transfer.
- R10: After reset, the block is idle with `rsp_done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken at this edge |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0 byte, 1 16-bit, 2/3 32-bit |
| req_write | input | 1 | 1 write, 0 read |
| req_io | input | 1 | 1 I/O space, 0 memory |
| req_code | input | 1 | 1 code fetch (memory reads only) |
| req_wdata | input | 32 | Right-aligned write data |
| rsp_done | output | 1 | Transfer complete pulse |
| rsp_rdata | output | 32 | Right-aligned read data |
| bus_waddr | output | ADDR_W-2 | Word address (lines 2 and up) |
| bus_be_n | output | 4 | Active-low byte-lane enables |
| bus_mio | output | 1 | Memory (1) or I/O (0) |
| bus_dc | output | 1 | Data (1) or control/code (0) |
| bus_wr | output | 1 | Write (1) or read (0) |
| bus_ads_n | output | 1 | Active-low address strobe |
| bus_wdata | output | 32 | Lane-aligned write data |
| bus_wdata_oe | output | 1 | Write data driven |
| bus_rdata | input | 32 | Lane-aligned read data |
| bus_rdy_n | input | 1 | Active-low ready |

## Verification
The strobe, word address, enables and code are due one clock after the edge that accepts a request. The write data lanes are due from the clock after that. The completion pulse and read data arrive one clock after the edge at which ready is sampled low. In a split transfer, the second strobe follows that edge directly. The bench drives every input and samples every output at the falling edge, and it advances clock by clock through strobe, wait and done cycles. It checks each result in the cycle it is due and confirms that nothing arrives early during wait states. Wait-state counts of zero to three are drawn at random and mixed with directed aligned, unaligned and boundary-crossing cases.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

  typedef enum logic [1:0] {
    SZ_B8  = 2'd0,
    SZ_B16 = 2'd1,
    SZ_B32 = 2'd2,
    SZ_RSV = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_STROBE = 2'd1,
    PH_WAIT   = 2'd2
  } bus_phase_e;

  // Bytes touched across two adjacent words, bit k = lane k of the span.
  function automatic logic [7:0] span_mask(input logic [1:0] off, input xfer_size_e sz);
    logic [7:0] base;
    case (sz)
      SZ_B8:   base = 8'h01;
      SZ_B16:  base = 8'h03;
      default: base = 8'h0F;
    endcase
    return base << off;
  endfunction

  // {memory/io, data/control, write/read}
  function automatic logic [2:0] cycle_code(input logic io, input logic code, input logic wr);
    logic [2:0] c;
    if (io)      c = {1'b0, 1'b1, wr};
    else if (wr) c = 3'b111;
    else if (code) c = 3'b100;
    else         c = 3'b110;
    return c;
  endfunction

  function automatic logic [63:0] lane_spread(input logic [31:0] d, input logic [1:0] off);
    return {32'b0, d} << {off, 3'b000};
  endfunction

  function automatic logic [31:0] size_keep(input xfer_size_e sz);
    case (sz)
      SZ_B8:   return 32'h0000_00FF;
      SZ_B16:  return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] lane_gather(input logic [63:0] b, input logic [1:0] off,
                                              input xfer_size_e sz);
    return 32'(b >> {off, 3'b000}) & size_keep(sz);
  endfunction

endpackage

// File: rtl/bcm_cycle_fsm.sv
module bcm_cycle_fsm
  import bcm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       split_i,
  input  logic       ready_i,
  output bus_phase_e phase_o,
  output logic       second_o,
  output logic       ready_evt_o,
  output logic       finish_o
);

  bus_phase_e phase_q;
  logic       second_q;

  assign phase_o     = phase_q;
  assign second_o    = second_q;
  assign ready_evt_o = (phase_q == PH_WAIT) && ready_i;
  assign finish_o    = ready_evt_o && (second_q || !split_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      second_q <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q  <= PH_STROBE;
            second_q <= 1'b0;
          end
        end
        PH_STROBE: phase_q <= PH_WAIT;
        PH_WAIT: begin
          if (ready_evt_o) begin
            if (finish_o) begin
              phase_q <= PH_IDLE;
            end else begin
              phase_q  <= PH_STROBE;
              second_q <= 1'b1;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bcm_lane_decode.sv
module bcm_lane_decode
  import bcm_pkg::*;
#(
  parameter int LANES = 4,
  localparam int DW = LANES * 8
) (
  input  logic [1:0]       off_i,
  input  xfer_size_e       size_i,
  input  logic             second_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [LANES-1:0] lanes_o,
  output logic             split_o,
  output logic [DW-1:0]    wlanes_o
);

  logic [2*LANES-1:0] span;
  logic [2*DW-1:0]    spread;

  assign span     = span_mask(off_i, size_i);
  assign spread   = lane_spread(wdata_i, off_i);
  assign split_o  = |span[2*LANES-1:LANES];
  assign lanes_o  = second_i ? span[2*LANES-1:LANES] : span[LANES-1:0];
  assign wlanes_o = second_i ? spread[2*DW-1:DW] : spread[DW-1:0];

endmodule

// File: rtl/bcm_read_merge.sv
module bcm_read_merge #(
  parameter int LANES = 4,
  localparam int DW = LANES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             cap_i,
  input  logic             second_i,
  input  logic [LANES-1:0] lanes_i,
  input  logic [DW-1:0]    bus_d_i,
  output logic [2*DW-1:0]  merged_o
);

  logic [2*DW-1:0] hold_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged_o[g*8 +: 8] =
      (cap_i && !second_i && lanes_i[g]) ? bus_d_i[g*8 +: 8] : hold_q[g*8 +: 8];
    assign merged_o[DW + g*8 +: 8] =
      (cap_i && second_i && lanes_i[g]) ? bus_d_i[g*8 +: 8] : hold_q[DW + g*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       hold_q <= '0;
    else if (clear_i) hold_q <= '0;
    else              hold_q <= merged_o;
  end

endmodule

// File: rtl/bcm_bus_master.sv
module bcm_bus_master
  import bcm_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int WADDR_W = ADDR_W - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_size,
  input  logic               req_write,
  input  logic               req_io,
  input  logic               req_code,
  input  logic [31:0]        req_wdata,
  output logic               rsp_done,
  output logic [31:0]        rsp_rdata,
  output logic [WADDR_W-1:0] bus_waddr,
  output logic [3:0]         bus_be_n,
  output logic               bus_mio,
  output logic               bus_dc,
  output logic               bus_wr,
  output logic               bus_ads_n,
  output logic [31:0]        bus_wdata,
  output logic               bus_wdata_oe,
  input  logic [31:0]        bus_rdata,
  input  logic               bus_rdy_n
);

  // captured request
  logic [ADDR_W-1:0] addr_q;
  xfer_size_e        size_q;
  logic [2:0]        code_q;
  logic              wr_q;
  logic [31:0]       wdata_q;

  // named internal events
  bus_phase_e  phase;
  logic        accept_evt;
  logic        ready_evt;
  logic        finish_evt;
  logic        second_w;
  logic        split_w;
  logic [3:0]  lanes_w;
  logic [31:0] wlanes_w;
  logic [63:0] merged_w;

  assign req_ready  = (phase == PH_IDLE);
  assign accept_evt = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      size_q  <= SZ_B8;
      code_q  <= 3'b110;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept_evt) begin
      addr_q  <= req_addr;
      size_q  <= xfer_size_e'(req_size);
      code_q  <= cycle_code(req_io, req_code, req_write);
      wr_q    <= req_write;
      wdata_q <= req_wdata;
    end
  end

  bcm_cycle_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (accept_evt),
    .split_i     (split_w),
    .ready_i     (!bus_rdy_n),
    .phase_o     (phase),
    .second_o    (second_w),
    .ready_evt_o (ready_evt),
    .finish_o    (finish_evt)
  );

  bcm_lane_decode #(.LANES(4)) u_dec (
    .off_i    (addr_q[1:0]),
    .size_i   (size_q),
    .second_i (second_w),
    .wdata_i  (wdata_q),
    .lanes_o  (lanes_w),
    .split_o  (split_w),
    .wlanes_o (wlanes_w)
  );

  bcm_read_merge #(.LANES(4)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (accept_evt),
    .cap_i    (ready_evt),
    .second_i (second_w),
    .lanes_i  (lanes_w),
    .bus_d_i  (bus_rdata),
    .merged_o (merged_w)
  );

  assign bus_waddr    = addr_q[ADDR_W-1:2] + WADDR_W'(second_w);
  assign bus_be_n     = (phase == PH_IDLE) ? 4'hF : ~lanes_w;
  assign bus_ads_n    = (phase != PH_STROBE);
  assign {bus_mio, bus_dc, bus_wr} = code_q;
  assign bus_wdata_oe = (phase == PH_WAIT) && wr_q;
  assign bus_wdata    = bus_wdata_oe ? wlanes_w : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= finish_evt;
      if (finish_evt && !wr_q) rsp_rdata <= lane_gather(merged_w, addr_q[1:0], size_q);
    end
  end

endmodule

// File: rtl/bcm_bus_master_chk.sv
module bcm_bus_master_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              accept_evt,
  input logic              ready_evt,
  input logic              finish_evt,
  input logic              second_w,
  input logic              rsp_done,
  input logic [ADDR_W-3:0] bus_waddr,
  input logic [3:0]        bus_be_n,
  input logic              bus_mio,
  input logic              bus_dc,
  input logic              bus_wr,
  input logic              bus_ads_n,
  input logic              bus_wdata_oe,
  input logic              bus_rdy_n
);

  // R5
  ads_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ads_n |=> bus_ads_n);

  // R5
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !ready_evt) |=>
      ($stable(bus_waddr) && $stable(bus_be_n) && $stable({bus_mio, bus_dc, bus_wr})));

  // R4
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ads_n |-> ({bus_mio, bus_dc, bus_wr} != 3'b000 &&
                    {bus_mio, bus_dc, bus_wr} != 3'b001 &&
                    {bus_mio, bus_dc, bus_wr} != 3'b101));

  // R2
  lanes_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ads_n |-> (bus_be_n != 4'hF));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_ads_n && bus_be_n == 4'hF && !bus_wdata_oe));

  // R9
  accept_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (!bus_ads_n && !req_ready));

  // R6
  wait_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && bus_ads_n && bus_rdy_n) |=> (bus_ads_n && !req_ready && !rsp_done));

  // R3
  second_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_evt && !finish_evt) |=> (!bus_ads_n && second_w));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(finish_evt));

  // R7
  wdata_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wdata_oe |-> (bus_ads_n && !req_ready && bus_wr));

endmodule

bind bcm_bus_master bcm_bus_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .accept_evt   (accept_evt),
  .ready_evt    (ready_evt),
  .finish_evt   (finish_evt),
  .second_w     (second_w),
  .rsp_done     (rsp_done),
  .bus_waddr    (bus_waddr),
  .bus_be_n     (bus_be_n),
  .bus_mio      (bus_mio),
  .bus_dc       (bus_dc),
  .bus_wr       (bus_wr),
  .bus_ads_n    (bus_ads_n),
  .bus_wdata_oe (bus_wdata_oe),
  .bus_rdy_n    (bus_rdy_n)
);

// File: tb/bcm_bus_master_test.sv
`timescale 1ns/1ps
module bcm_bus_master_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic        req_io = 1'b0;
  logic        req_code = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic [29:0] bus_waddr;
  logic [3:0]  bus_be_n;
  logic        bus_mio, bus_dc, bus_wr;
  logic        bus_ads_n;
  logic [31:0] bus_wdata;
  logic        bus_wdata_oe;
  logic [31:0] bus_rdata = '0;
  logic        bus_rdy_n = 1'b1;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  bcm_bus_master #(.ADDR_W(32)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_io(req_io),
    .req_code(req_code), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_waddr(bus_waddr), .bus_be_n(bus_be_n),
    .bus_mio(bus_mio), .bus_dc(bus_dc), .bus_wr(bus_wr),
    .bus_ads_n(bus_ads_n), .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe),
    .bus_rdata(bus_rdata), .bus_rdy_n(bus_rdy_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [7:0] exp_span(input logic [1:0] off, input logic [1:0] sz);
    logic [7:0] m = '0;
    for (int i = 0; i < nbytes(sz); i++) m[int'(off) + i] = 1'b1;
    return m;
  endfunction

  function automatic logic [2:0] exp_code(input logic io, input logic code, input logic wr);
    if (io) return wr ? 3'b011 : 3'b010;
    if (wr) return 3'b111;
    return code ? 3'b100 : 3'b110;
  endfunction

  task automatic xfer(input logic [31:0] addr, input logic [1:0] sz, input logic wr,
                      input logic io, input logic code, input logic [31:0] wd,
                      input bit hold_valid);
    logic [7:0]  span;
    logic [3:0]  lanes;
    logic [31:0] rd [2];
    logic [31:0] exp_rd;
    logic [29:0] exp_wa;
    int np, off, w, lane, idx;
    span = exp_span(addr[1:0], sz);
    np   = (span[7:4] != 4'h0) ? 2 : 1;
    off  = int'(addr[1:0]);
    @(negedge clk);
    req_addr = addr; req_size = sz; req_write = wr; req_io = io;
    req_code = code; req_wdata = wd; req_valid = 1'b1;
    for (int p = 0; p < np; p++) begin
      @(negedge clk);
      bus_rdy_n = 1'b1;
      if (p == 0) begin
        if (hold_valid) req_addr = ~addr;
        else req_valid = 1'b0;
      end
      lanes  = (p == 1) ? span[7:4] : span[3:0];
      exp_wa = addr[31:2] + 30'(p);
      chk(bus_ads_n == 1'b0, "R5 strobe", 64'(bus_ads_n), 64'd0);
      chk(bus_waddr == exp_wa, "R1 word address", 64'(bus_waddr), 64'(exp_wa));
      chk(bus_be_n == ~lanes, (p == 1) ? "R3 second-cycle enables" : "R2 enables",
          64'(bus_be_n), 64'(~lanes));
      chk({bus_mio, bus_dc, bus_wr} == exp_code(io, code, wr), "R4 cycle code",
          64'({bus_mio, bus_dc, bus_wr}), 64'(exp_code(io, code, wr)));
      chk(!req_ready && !rsp_done, "R9 busy", 64'({req_ready, rsp_done}), 64'd0);
      w = $urandom_range(0, 3);
      rd[p] = $urandom;
      for (int k = 0; k <= w; k++) begin
        @(negedge clk);
        chk(bus_ads_n && !rsp_done && bus_be_n == ~lanes && bus_waddr == exp_wa,
            "R6 wait state hold", 64'({bus_ads_n, rsp_done, bus_be_n}),
            64'({1'b1, 1'b0, ~lanes}));
        chk(bus_wdata_oe == wr, "R7 write enable window", 64'(bus_wdata_oe), 64'(wr));
        if (wr) begin
          for (int l = 0; l < 4; l++) begin
            if (lanes[l]) begin
              idx = 4 * p + l - off;
              chk(bus_wdata[l*8 +: 8] == wd[idx*8 +: 8], "R7 write lane data",
                  64'(bus_wdata[l*8 +: 8]), 64'(wd[idx*8 +: 8]));
            end
          end
        end
        bus_rdy_n = (k == w) ? 1'b0 : 1'b1;
        bus_rdata = rd[p];
      end
    end
    @(negedge clk);
    bus_rdy_n = 1'b1;
    req_valid = 1'b0;
    chk(rsp_done == 1'b1, "R8 done pulse", 64'(rsp_done), 64'd1);
    if (!wr) begin
      exp_rd = '0;
      for (int i = 0; i < nbytes(sz); i++) begin
        lane = off + i;
        exp_rd[i*8 +: 8] = rd[lane / 4][(lane % 4)*8 +: 8];
      end
      chk(rsp_rdata == exp_rd, "R8 read data", 64'(rsp_rdata), 64'(exp_rd));
    end
    chk(req_ready && bus_ads_n && bus_be_n == 4'hF, "R9 idle outputs",
        64'({req_ready, bus_ads_n, bus_be_n}), 64'({1'b1, 1'b1, 4'hF}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(req_ready && bus_ads_n && bus_be_n == 4'hF && !rsp_done && !bus_wdata_oe,
        "R10 reset state", 64'({req_ready, bus_ads_n, bus_be_n, rsp_done, bus_wdata_oe}),
        64'({1'b1, 1'b1, 4'hF, 1'b0, 1'b0}));

    // directed lane cases (R2), codes (R4)
    xfer(32'h0000_0000, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    xfer(32'h0001_7803, 2'd0, 1'b0, 1'b0, 1'b1, 32'h0, 1'b0);
    xfer(32'h0001_0002, 2'd1, 1'b1, 1'b0, 1'b0, 32'hCAFE_BEEF, 1'b0);
    xfer(32'h0002_1029, 2'd1, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0);
    xfer(32'h0001_6314, 2'd2, 1'b1, 1'b1, 1'b1, 32'h1234_5678, 1'b0);
    xfer(32'h0001_6314, 2'd3, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    // R3 splits, including word-address wrap
    xfer(32'h0000_1003, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    xfer(32'h0000_2001, 2'd2, 1'b1, 1'b0, 1'b0, 32'hA1B2_C3D4, 1'b0);
    xfer(32'hFFFF_FFFE, 2'd2, 1'b0, 1'b0, 1'b1, 32'h0, 1'b0);
    // R9 request held during a transfer has no effect on it
    xfer(32'h0000_3002, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0BAD_F00D, 1'b1);

    for (int t = 0; t < 300; t++) begin
      xfer($urandom, 2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
           1'($urandom), $urandom, 1'($urandom_range(0, 3) == 0));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule